// File: doc/BRIEF.md
# SD Host Data FIFO and Transfer Control

This block is the data side of an SD host controller. Software programs a total byte count, a timeout count and a control word holding the block size exponent, the direction, a DMA enable, a batch (threshold) mode and a FIFO flush. It then moves 32-bit words through a single window address, one word per access. Behind the window sits a FIFO that a card-side word stream fills (reads from the card) or drains (writes to the card). The DAT-line serialiser and its CRC16 are outside the block. The environment reports one CRC verdict per block on a single input.

The block tells the shared status logic when the FIFO needs software or DMA attention. It also reports when the programmed count has crossed the card interface, whether every block passed its CRC, and whether the card stalled past the timeout. With DMA enabled, a request line follows the service condition. A feature register publishes the FIFO depth in words.

Top module: `sdd_data_path`

## Requirements
- R1: After reset all status outputs, `dma_req`, `card_tx_valid` and `card_rx_ready` are 0. The control, timer and length registers read 0.
- R2: The length register at address 0x24 keeps only bits 23:0 of a write. Bits 31:24 read back as 0.
- R3: A read of address 0x44 returns the FIFO depth in words (default 8).
- R4: In write direction (control bit 4 = 1), words written to the window at 0x40 leave on `card_tx_data` in the order written. `card_tx_valid` is high only while the transfer runs, the FIFO holds data and card words remain.
- R5: In read direction (control bit 4 = 0), card words are returned by window reads in arrival order. `card_rx_ready` is low whenever the FIFO is full, no card words remain, or no transfer runs.
- R6: Let the batch be the FIFO depth when control bit 7 = 0, and half the depth when it is 1. Let `want` be the smaller of the batch and the number of words software still owes. In write direction, `sts_fifo_urun` is high when the free slots are at least `want`. In read direction, `sts_fifo_orun` is high when the stored words are at least `want`. Both are low once software owes nothing.
- R7: `dma_req` equals (`sts_fifo_urun` or `sts_fifo_orun`) when control bit 5 = 1, and is 0 when it is 0.
- R8: Once ceil(length/4) words have crossed the card side, `sts_data_end` rises. `sts_crc_ok` rises with it if every sampled `card_blk_crc_ok` was 1; otherwise `sts_crc_fail` rises instead. The CRC input is sampled on the last word of each block of 2^(bits 3:0) bytes and on the final word. The exponent is clamped to the range 2 to 11 (4 to 2048 bytes).
- R9: The timeout counter loads from the timer register (address 0x20) at start and reloads on every card word. It decrements on each cycle with no card word. In an idle cycle where it already reads 0, `sts_timeout` rises and the transfer stops: no further card handshakes, and the service flags drop.
- R10: A control write with bit 8 = 1 empties the FIFO, clears all status, and stops the transfer. Bit 8 always reads back as 0.
- R11: Starting a transfer (control write with bit 6 = 1 and bit 8 = 0) with length 0 raises `sts_data_end` and `sts_crc_ok` on the next cycle.
- R12: Window writes in read direction, and window reads in write direction, leave the FIFO unchanged. Such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the window) |
| bus_addr | input | 7 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| card_tx_valid | output | 1 | Word available for the card |
| card_tx_ready | input | 1 | Card accepts the word |
| card_tx_data | output | 32 | Word to the card |
| card_rx_valid | input | 1 | Card offers a word |
| card_rx_ready | output | 1 | Block accepts the card word |
| card_rx_data | input | 32 | Word from the card |
| card_blk_crc_ok | input | 1 | CRC verdict for the block ending with this word |
| dma_req | output | 1 | DMA service request |
| sts_fifo_urun | output | 1 | Write direction: room for the next batch |
| sts_fifo_orun | output | 1 | Read direction: a batch is waiting |
| sts_data_end | output | 1 | All card words transferred |
| sts_crc_ok | output | 1 | All blocks passed CRC |
| sts_crc_fail | output | 1 | At least one block failed CRC |
| sts_timeout | output | 1 | Card stalled past the timeout |

## Verification
The bench aims at the tail of each transfer. When fewer words remain than a batch, a design that compared against the full batch would leave the service flag low forever and hang the transfer. It also plants a CRC failure on a block boundary that is not the final word. A design that sampled only the last word would report success there. The stall test counts exactly timer+1 idle cycles, so an off-by-one reload, or a counter that keeps running after expiry, shows on the cycle the flag rises. Flushing mid-transfer, then poking the window in the wrong direction, exposes a FIFO that keeps stale words or accepts pushes that should be dropped.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h1C;
  localparam logic [7:0] OFS_TIMER = 8'h20;
  localparam logic [7:0] OFS_LEN   = 8'h24;
  localparam logic [7:0] OFS_WIN   = 8'h40;
  localparam logic [7:0] OFS_FEAT  = 8'h44;

  // control word, bit 7 down to bit 0
  typedef struct packed {
    logic       batch_half;
    logic       run_en;
    logic       dma_en;
    logic       to_card;
    logic [3:0] blk_log2;
  } ctrl_t;
endpackage

// File: rtl/sdd_fifo.sv
module sdd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + PTR_W'(1);
      if (do_pop)  rp_d = rp_q + PTR_W'(1);
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; write enable only
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wp_q] <= wdata;
  end
endmodule

// File: rtl/sdd_xfer_ctrl.sv
module sdd_xfer_ctrl #(
  parameter int WCNT_W       = 23,
  parameter int TMR_W        = 32,
  parameter int MAX_BLK_LOG2 = 11,
  localparam int BLK_W = MAX_BLK_LOG2 - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic              halt,
  input  logic [WCNT_W-1:0] len_words,
  input  logic [TMR_W-1:0]  tmr_load,
  input  logic [3:0]        blk_log2,
  input  logic              beat,
  input  logic              crc_in,
  input  logic              host_ack,
  output logic              armed,
  output logic              card_more,
  output logic [WCNT_W-1:0] host_left,
  output logic              data_end,
  output logic              crc_ok,
  output logic              crc_fail,
  output logic              timeout
);
  logic              armed_q, armed_d, fail_q, fail_d, fail_n;
  logic [WCNT_W-1:0] cleft_q, cleft_d, hleft_q, hleft_d;
  logic [BLK_W-1:0]  bcnt_q, bcnt_d, blk_last;
  logic [TMR_W-1:0]  tmo_q, tmo_d;
  logic              dend_q, dend_d, cok_q, cok_d, cfail_q, cfail_d, tout_q, tout_d;
  logic [3:0]        lg;
  logic              last_word, blk_end;

  always_comb begin
    if (blk_log2 < 4'd2)                     lg = 4'd2;
    else if (blk_log2 > 4'(MAX_BLK_LOG2))    lg = 4'(MAX_BLK_LOG2);
    else                                     lg = blk_log2;
  end
  assign blk_last  = BLK_W'((32'd1 << (lg - 4'd2)) - 32'd1);
  assign last_word = (cleft_q == WCNT_W'(1));
  assign blk_end   = (bcnt_q == blk_last) | last_word;
  assign fail_n    = fail_q | (blk_end & ~crc_in);

  always_comb begin
    armed_d = armed_q; cleft_d = cleft_q; hleft_d = hleft_q; bcnt_d = bcnt_q;
    fail_d  = fail_q;  tmo_d   = tmo_q;   dend_d  = dend_q;  cok_d  = cok_q;
    cfail_d = cfail_q; tout_d  = tout_q;
    if (flush) begin
      armed_d = 1'b0; cleft_d = '0; hleft_d = '0; bcnt_d = '0; fail_d = 1'b0;
      tmo_d = '0; dend_d = 1'b0; cok_d = 1'b0; cfail_d = 1'b0; tout_d = 1'b0;
    end else if (start) begin
      armed_d = 1'b1; cleft_d = len_words; hleft_d = len_words; bcnt_d = '0;
      fail_d  = 1'b0; tmo_d = tmr_load; tout_d = 1'b0; cfail_d = 1'b0;
      dend_d  = (len_words == '0);
      cok_d   = (len_words == '0);
    end else if (halt) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (host_ack && hleft_q != '0) hleft_d = hleft_q - WCNT_W'(1);
      if (cleft_q != '0) begin
        if (beat) begin
          tmo_d   = tmr_load;
          cleft_d = cleft_q - WCNT_W'(1);
          bcnt_d  = blk_end ? '0 : bcnt_q + BLK_W'(1);
          fail_d  = fail_n;
          if (last_word) begin
            dend_d  = 1'b1;
            cok_d   = ~fail_n;
            cfail_d = fail_n;
          end
        end else if (tmo_q == '0) begin
          tout_d  = 1'b1;
          armed_d = 1'b0;
        end else begin
          tmo_d = tmo_q - TMR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; cleft_q <= '0; hleft_q <= '0; bcnt_q <= '0; fail_q <= 1'b0;
      tmo_q <= '0; dend_q <= 1'b0; cok_q <= 1'b0; cfail_q <= 1'b0; tout_q <= 1'b0;
    end else begin
      armed_q <= armed_d; cleft_q <= cleft_d; hleft_q <= hleft_d; bcnt_q <= bcnt_d;
      fail_q <= fail_d; tmo_q <= tmo_d; dend_q <= dend_d; cok_q <= cok_d;
      cfail_q <= cfail_d; tout_q <= tout_d;
    end
  end

  assign armed     = armed_q;
  assign card_more = (cleft_q != '0);
  assign host_left = hleft_q;
  assign data_end  = dend_q;
  assign crc_ok    = cok_q;
  assign crc_fail  = cfail_q;
  assign timeout   = tout_q;
endmodule

// File: rtl/sdd_data_path.sv
module sdd_data_path #(
  parameter int FIFO_DEPTH   = 8,
  parameter int LEN_W        = 24,
  parameter int TMR_W        = 32,
  parameter int ADDR_W       = 7,
  parameter int MAX_BLK_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  output logic [31:0]       card_tx_data,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  input  logic [31:0]       card_rx_data,
  input  logic              card_blk_crc_ok,
  output logic              dma_req,
  output logic              sts_fifo_urun,
  output logic              sts_fifo_orun,
  output logic              sts_data_end,
  output logic              sts_crc_ok,
  output logic              sts_crc_fail,
  output logic              sts_timeout
);
  import sdd_pkg::*;
  localparam int CNT_W  = $clog2(FIFO_DEPTH) + 1;
  localparam int WCNT_W = LEN_W - 1;
  localparam int BATCH_FULL = FIFO_DEPTH;
  localparam int BATCH_HALF = FIFO_DEPTH / 2;

  ctrl_t             ctrl_q, ctrl_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              sel_ctrl, sel_tmr, sel_len, sel_win, sel_feat;
  logic              wr_ctrl, do_flush, do_start, do_halt;
  logic              win_wr, win_rd, dir_wr;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0]       fifo_wdata, fifo_rdata;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              armed, card_more, tx_beat, rx_beat, host_ack;
  logic [WCNT_W-1:0] host_left, len_words, batch, want, stored, free_slots;
  logic              svc_wr, svc_rd;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_tmr  = (bus_addr == ADDR_W'(OFS_TIMER));
  assign sel_len  = (bus_addr == ADDR_W'(OFS_LEN));
  assign sel_win  = (bus_addr == ADDR_W'(OFS_WIN));
  assign sel_feat = (bus_addr == ADDR_W'(OFS_FEAT));

  assign wr_ctrl  = bus_wr & sel_ctrl;
  assign do_flush = wr_ctrl & bus_wdata[8];
  assign do_start = wr_ctrl & ~bus_wdata[8] & bus_wdata[6];
  assign do_halt  = wr_ctrl & ~bus_wdata[8] & ~bus_wdata[6];
  assign win_wr   = bus_wr & sel_win;
  assign win_rd   = bus_rd & sel_win;
  assign dir_wr   = ctrl_q.to_card;

  // register next-state
  always_comb begin
    ctrl_d = ctrl_q;
    len_d  = len_q;
    tmr_d  = tmr_q;
    if (wr_ctrl)           ctrl_d = ctrl_t'(bus_wdata[7:0]);
    if (bus_wr && sel_len) len_d  = bus_wdata[LEN_W-1:0];
    if (bus_wr && sel_tmr) tmr_d  = bus_wdata[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      tmr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      len_q  <= len_d;
      tmr_q  <= tmr_d;
    end
  end

  // card-side handshakes
  assign card_tx_valid = armed & card_more & dir_wr & ~fifo_empty;
  assign card_rx_ready = armed & card_more & ~dir_wr & ~fifo_full;
  assign tx_beat       = card_tx_valid & card_tx_ready;
  assign rx_beat       = card_rx_valid & card_rx_ready;
  assign card_tx_data  = fifo_rdata;

  assign fifo_push  = dir_wr ? (win_wr & ~fifo_full) : rx_beat;
  assign fifo_pop   = dir_wr ? tx_beat : (win_rd & ~fifo_empty);
  assign fifo_wdata = dir_wr ? bus_wdata : card_rx_data;
  assign host_ack   = armed & (dir_wr ? (win_wr & ~fifo_full) : (win_rd & ~fifo_empty));
  assign len_words  = len_q[LEN_W-1:2] + WCNT_W'(|len_q[1:0]);

  sdd_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(do_flush), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  sdd_xfer_ctrl #(.WCNT_W(WCNT_W), .TMR_W(TMR_W), .MAX_BLK_LOG2(MAX_BLK_LOG2)) u_xfer (
    .clk(clk), .rst_n(rst_n), .flush(do_flush), .start(do_start), .halt(do_halt),
    .len_words(len_words), .tmr_load(tmr_q), .blk_log2(ctrl_q.blk_log2),
    .beat(tx_beat | rx_beat), .crc_in(card_blk_crc_ok), .host_ack(host_ack),
    .armed(armed), .card_more(card_more), .host_left(host_left),
    .data_end(sts_data_end), .crc_ok(sts_crc_ok), .crc_fail(sts_crc_fail),
    .timeout(sts_timeout)
  );

  // service condition
  assign batch      = ctrl_q.batch_half ? WCNT_W'(BATCH_HALF) : WCNT_W'(BATCH_FULL);
  assign want       = (host_left < batch) ? host_left : batch;
  assign stored     = WCNT_W'(fifo_cnt);
  assign free_slots = WCNT_W'(FIFO_DEPTH) - stored;
  assign svc_wr     = armed & dir_wr & (host_left != '0) & (free_slots >= want);
  assign svc_rd     = armed & ~dir_wr & (host_left != '0) & (stored >= want);
  assign sts_fifo_urun = svc_wr;
  assign sts_fifo_orun = svc_rd;
  assign dma_req       = ctrl_q.dma_en & (svc_wr | svc_rd);

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = 32'(ctrl_q);
    else if (sel_tmr)  bus_rdata = 32'(tmr_q);
    else if (sel_len)  bus_rdata = 32'(len_q);
    else if (sel_win)  bus_rdata = (!dir_wr && !fifo_empty) ? fifo_rdata : '0;
    else if (sel_feat) bus_rdata = 32'(FIFO_DEPTH);
  end
endmodule

// File: rtl/sdd_data_path_chk.sv
module sdd_data_path_chk (
  input logic clk,
  input logic rst_n,
  input logic card_tx_valid,
  input logic card_rx_ready,
  input logic dma_req,
  input logic sts_fifo_urun,
  input logic sts_fifo_orun,
  input logic sts_data_end,
  input logic sts_crc_ok,
  input logic sts_crc_fail,
  input logic sts_timeout,
  input logic fifo_empty,
  input logic fifo_full,
  input logic flush
);
  assert_tx_has_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> !fifo_empty);

  assert_rx_has_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> !fifo_full);

  assert_one_service_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_fifo_urun && sts_fifo_orun));

  assert_dma_follows_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (sts_fifo_urun || sts_fifo_orun));

  assert_end_has_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_data_end |-> (sts_crc_ok != sts_crc_fail));

  assert_stall_stops_card_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_timeout |-> (!card_tx_valid && !card_rx_ready));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_empty);
endmodule

bind sdd_data_path sdd_data_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .card_tx_valid(card_tx_valid), .card_rx_ready(card_rx_ready),
  .dma_req(dma_req), .sts_fifo_urun(sts_fifo_urun), .sts_fifo_orun(sts_fifo_orun),
  .sts_data_end(sts_data_end), .sts_crc_ok(sts_crc_ok), .sts_crc_fail(sts_crc_fail),
  .sts_timeout(sts_timeout), .fifo_empty(fifo_empty), .fifo_full(fifo_full), .flush(do_flush)
);

// File: tb/test_sdd_data_path.sv
module test_sdd_data_path;
  localparam int D = 8;
  localparam logic [6:0] A_CTRL = 7'h1C, A_TMR = 7'h20, A_LEN = 7'h24, A_WIN = 7'h40, A_FEAT = 7'h44;

  logic clk, rst_n, bus_wr, bus_rd;
  logic [6:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, card_tx_data, card_rx_data;
  logic card_tx_valid, card_tx_ready, card_rx_valid, card_rx_ready, card_blk_crc_ok;
  logic dma_req, sts_fifo_urun, sts_fifo_orun, sts_data_end, sts_crc_ok, sts_crc_fail, sts_timeout;

  sdd_data_path i_sdd_data_path (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_tx_valid(card_tx_valid),
    .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .card_rx_data(card_rx_data), .card_blk_crc_ok(card_blk_crc_ok),
    .dma_req(dma_req), .sts_fifo_urun(sts_fifo_urun), .sts_fifo_orun(sts_fifo_orun),
    .sts_data_end(sts_data_end), .sts_crc_ok(sts_crc_ok), .sts_crc_fail(sts_crc_fail),
    .sts_timeout(sts_timeout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit model_on = 0, done = 0;

  // reference model state
  logic [31:0] mq[$];
  bit m_armed, m_fail, m_dend, m_cok, m_cfail, m_tout;
  int m_cleft, m_hleft, m_bcnt;
  longint m_tmo;
  logic [7:0] m_ctrl;
  logic [23:0] m_len;
  logic [31:0] m_tmr;

  // card environment
  bit tx_en = 0, rx_en = 0;
  int beats = 0, bad_beat = -1, rx_cnt = 0;
  logic [31:0] got_tx[$];
  logic [31:0] last_rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit dirw, empty, full, txv, rxr, urun, orun;
    int batch, want;
    logic [31:0] er;
    dirw  = m_ctrl[4];
    empty = (mq.size() == 0);
    full  = (mq.size() == D);
    txv   = m_armed && m_cleft > 0 && dirw && !empty;
    rxr   = m_armed && m_cleft > 0 && !dirw && !full;
    batch = m_ctrl[7] ? D / 2 : D;
    want  = (m_hleft < batch) ? m_hleft : batch;
    urun  = m_armed && dirw && m_hleft > 0 && (D - mq.size()) >= want;
    orun  = m_armed && !dirw && m_hleft > 0 && mq.size() >= want;
    case (bus_addr)
      A_CTRL: er = {24'h0, m_ctrl};
      A_TMR:  er = m_tmr;
      A_LEN:  er = {8'h0, m_len};
      A_WIN:  er = (!dirw && !empty) ? mq[0] : 32'h0;
      A_FEAT: er = D;
      default: er = 32'h0;
    endcase
    chk(bus_rdata === er, "R12 rdata", bus_rdata, er);
    chk(card_tx_valid === txv, "R4 tx_valid", 32'(card_tx_valid), 32'(txv));
    if (txv) chk(card_tx_data === mq[0], "R4 tx_data", card_tx_data, mq[0]);
    chk(card_rx_ready === rxr, "R5 rx_ready", 32'(card_rx_ready), 32'(rxr));
    chk(sts_fifo_urun === urun, "R6 urun", 32'(sts_fifo_urun), 32'(urun));
    chk(sts_fifo_orun === orun, "R6 orun", 32'(sts_fifo_orun), 32'(orun));
    chk(dma_req === (m_ctrl[5] && (urun || orun)), "R7 dma_req", 32'(dma_req), 32'(m_ctrl[5] && (urun || orun)));
    chk(sts_data_end === m_dend, "R8 data_end", 32'(sts_data_end), 32'(m_dend));
    chk(sts_crc_ok === m_cok, "R8 crc_ok", 32'(sts_crc_ok), 32'(m_cok));
    chk(sts_crc_fail === m_cfail, "R8 crc_fail", 32'(sts_crc_fail), 32'(m_cfail));
    chk(sts_timeout === m_tout, "R9 timeout", 32'(sts_timeout), 32'(m_tout));
  endtask

  task automatic model_update();
    bit dirw, empty, full, txv, rxr, txb, rxb, winw, winr, hpush, hpop, ack, bend;
    int lg, bw;
    dirw  = m_ctrl[4];
    empty = (mq.size() == 0);
    full  = (mq.size() == D);
    txv   = m_armed && m_cleft > 0 && dirw && !empty;
    rxr   = m_armed && m_cleft > 0 && !dirw && !full;
    txb   = txv && card_tx_ready;
    rxb   = rxr && card_rx_valid;
    winw  = bus_wr && bus_addr == A_WIN;
    winr  = bus_rd && bus_addr == A_WIN;
    hpush = dirw && winw && !full;
    hpop  = !dirw && winr && !empty;
    ack   = m_armed && (hpush || hpop);
    if (txb || hpop) void'(mq.pop_front());
    if (hpush) mq.push_back(bus_wdata);
    if (rxb) begin mq.push_back(card_rx_data); rx_cnt++; end
    lg = m_ctrl[3:0];
    if (lg < 2) lg = 2;
    if (lg > 11) lg = 11;
    bw = 1 << (lg - 2);
    if (bus_wr && bus_addr == A_CTRL) begin
      m_ctrl = bus_wdata[7:0];
      if (bus_wdata[8]) begin
        mq.delete();
        m_armed = 0; m_cleft = 0; m_hleft = 0; m_bcnt = 0; m_fail = 0; m_tmo = 0;
        m_dend = 0; m_cok = 0; m_cfail = 0; m_tout = 0;
      end else if (bus_wdata[6]) begin
        m_armed = 1; m_cleft = (m_len + 3) / 4; m_hleft = m_cleft; m_bcnt = 0; m_fail = 0;
        m_tmo = m_tmr; m_tout = 0; m_cfail = 0;
        m_dend = (m_cleft == 0); m_cok = (m_cleft == 0);
        beats = 0;
      end else m_armed = 0;
    end else if (m_armed) begin
      if (ack && m_hleft > 0) m_hleft--;
      if (m_cleft > 0) begin
        if (txb || rxb) begin
          m_tmo = m_tmr;
          bend = (m_bcnt == bw - 1) || (m_cleft == 1);
          if (bend) begin
            if (!card_blk_crc_ok) m_fail = 1;
            m_bcnt = 0;
          end else m_bcnt++;
          if (m_cleft == 1) begin m_dend = 1; m_cok = !m_fail; m_cfail = m_fail; end
          m_cleft--;
          beats++;
        end else if (m_tmo == 0) begin
          m_tout = 1; m_armed = 0;
        end else m_tmo--;
      end
    end
    if (bus_wr && bus_addr == A_TMR) m_tmr = bus_wdata;
    if (bus_wr && bus_addr == A_LEN) m_len = bus_wdata[23:0];
  endtask

  // one clock: drive card side, compare, advance
  task automatic step();
    card_tx_ready   = tx_en && ($urandom % 3 != 0);
    card_rx_valid   = rx_en && ($urandom % 4 != 0);
    card_rx_data    = 32'hA000_0000 + 32'(rx_cnt);
    card_blk_crc_ok = (beats != bad_beat);
    #1;
    last_rd = bus_rdata;
    if (model_on) compare();
    if (card_tx_valid && card_tx_ready) got_tx.push_back(card_tx_data);
    @(posedge clk);
    if (model_on) model_update();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a; step(); d = last_rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = A_CTRL; bus_wdata = 0;
    card_tx_ready = 0; card_rx_valid = 0; card_rx_data = 0; card_blk_crc_ok = 1;
    m_armed = 0; m_fail = 0; m_dend = 0; m_cok = 0; m_cfail = 0; m_tout = 0;
    m_cleft = 0; m_hleft = 0; m_bcnt = 0; m_tmo = 0; m_ctrl = 0; m_len = 0; m_tmr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sts_fifo_urun, sts_fifo_orun, sts_data_end, sts_crc_ok, sts_crc_fail, sts_timeout,
         dma_req, card_tx_valid, card_rx_ready} === 9'b0, "R1 outputs in reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    model_on = 1;
    rd(A_CTRL, v); chk(v === 0, "R1 ctrl", v, 0);
    rd(A_LEN, v);  chk(v === 0, "R1 len", v, 0);
    rd(A_TMR, v);  chk(v === 0, "R1 timer", v, 0);

    // R2 / R3
    wr(A_LEN, 32'h01FF_FFF0);
    rd(A_LEN, v);  chk(v === 32'h00FF_FFF0, "R2 length masked", v, 32'h00FF_FFF0);
    rd(A_FEAT, v); chk(v === D, "R3 feature depth", v, D);

    // write transfer: 8 words, 16-byte blocks, full batches
    wr(A_CTRL, 32'h100);
    wr(A_LEN, 32);
    wr(A_TMR, 60);
    tx_en = 1; bad_beat = -1; got_tx.delete();
    wr(A_CTRL, 32'h54);
    rd(A_WIN, v); chk(v === 0, "R12 window read in write direction", v, 0);
    for (int i = 0; i < 8;) begin
      if (sts_fifo_urun) begin wr(A_WIN, 32'h5100_0000 + 32'(i)); i++; end
      else step();
    end
    while (!sts_data_end) step();
    chk(got_tx.size() == 8, "R4 word count to card", got_tx.size(), 8);
    for (int i = 0; i < 8 && i < got_tx.size(); i++)
      chk(got_tx[i] === 32'h5100_0000 + 32'(i), "R4 card order", got_tx[i], 32'h5100_0000 + 32'(i));
    chk(sts_crc_ok === 1'b1, "R8 clean write verdict", 32'(sts_crc_ok), 1);
    tx_en = 0;

    // read transfer: 10 words, 8-byte blocks, half batches, DMA, CRC fail on block 2
    wr(A_CTRL, 32'h100);
    wr(A_LEN, 40);
    wr(A_TMR, 60);
    rx_cnt = 0; bad_beat = 3; rx_en = 1;
    wr(A_CTRL, 32'hE3);
    for (int i = 0; i < 10;) begin
      if (sts_fifo_orun) begin
        rd(A_WIN, v);
        chk(v === 32'hA000_0000 + 32'(i), "R5 window order", v, 32'hA000_0000 + 32'(i));
        i++;
      end else step();
    end
    while (!sts_data_end) step();
    chk(sts_crc_fail === 1'b1, "R8 block crc fail reported", 32'(sts_crc_fail), 1);
    rx_en = 0; bad_beat = -1;

    // R10 flush mid-transfer, then R12 wrong-direction window write
    wr(A_CTRL, 32'h100);
    wr(A_LEN, 64);
    rx_en = 1;
    wr(A_CTRL, 32'h42);
    idle(6);
    rx_en = 0;
    wr(A_CTRL, 32'h100);
    rd(A_WIN, v); chk(v === 0, "R10 fifo emptied", v, 0);
    chk(sts_fifo_orun === 0, "R10 service cleared", 32'(sts_fifo_orun), 0);
    rd(A_CTRL, v); chk(v[8] === 1'b0, "R10 flush bit not kept", v, 0);
    wr(A_WIN, 32'hDEAD_BEEF);
    rd(A_WIN, v); chk(v === 0, "R12 window write ignored", v, 0);

    // R9 stall
    wr(A_LEN, 16);
    wr(A_TMR, 5);
    wr(A_CTRL, 32'h42);
    idle(5);
    chk(sts_timeout === 0, "R9 not yet expired", 32'(sts_timeout), 0);
    idle(1);
    chk(sts_timeout === 1, "R9 expired", 32'(sts_timeout), 1);
    rx_en = 1; idle(3); rx_en = 0;
    chk(card_rx_ready === 0, "R9 card stopped", 32'(card_rx_ready), 0);

    // R11 zero length
    wr(A_CTRL, 32'h100);
    wr(A_LEN, 0);
    wr(A_CTRL, 32'h40);
    chk(sts_data_end === 1 && sts_crc_ok === 1, "R11 zero length end", {sts_data_end, sts_crc_ok}, 2'b11);
    idle(2);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule